// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a one-shot watchdog that counts a 16 Hz tick input and fires when a software-chosen interval runs out. The interval is taken from a single control byte: a five-bit multiplier and a two-bit resolution code together give a timeout of `multiplier × 4^resolution` ticks. Each tick is one sixteenth of a second, so the range runs from 1/16 s up to 124 s. A multiplier of zero switches the watchdog off.

Software keeps the watchdog alive in one of two ways. It can rewrite the control byte, which loads a new interval and also clears the expiry flag. It can instead read the flag register, which restarts the count using the interval already held in the control byte.

When the count runs out, the flag bit is set. The top bit of the control byte, the steering bit, then picks the action:
- **Steering bit set:** the block emits a one-cycle system reset request. It clears the control byte to zero. It emits a one-cycle clear strobe, used to drop a related enable bit held in another register.
- **Steering bit clear:** the block emits a one-cycle interrupt pulse.

Top module: `wdt_steer`

## Requirements
- R1: After synchronous reset the control byte reads 0x00, the flag register reads 0x00, `rst_req`, `irq` and `ext_clr` are low, and no expiry happens until the watchdog is armed.
- R2: A write to the control address stores the full byte. A read of the control address returns it on `reg_rdata` in the cycle after the read strobe. Bits 1:0 are the resolution code, bits 6:2 are the multiplier and bit 7 is the steering bit.
- R3: After a restart, expiry happens on exactly the `multiplier × 4^resolution`-th tick pulse, not on any earlier tick.
- R4: Expiry sets bit 7 of the flag register. The other seven bits of the flag register always read 0.
- R5: On expiry with the steering bit clear, `irq` is high for exactly one clock cycle and `rst_req` stays low.
- R6: On expiry with the steering bit set:
  - `rst_req` and `ext_clr` are high for exactly one clock cycle;
  - the control byte becomes 0x00;
  - `irq` stays low.
- R7: A write to the control address clears the flag bit and restarts the count with the newly written interval.
- R8: A read of the flag address restarts the count with the interval held in the control byte.
- R9: Writes to the flag address have no effect on the flag register.
- R10: With a multiplier of zero the watchdog never expires, however many ticks arrive.
- R11: After one expiry no further expiry happens until the next restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per 1/16 s |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 13 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt pulse |
| ext_clr | output | 1 | One-cycle strobe to clear the related enable bit elsewhere |

## Verification
The assertions assume that a register write and an expiry never land on the same clock edge. They also assume that `reg_wr` and `reg_rd` are never raised together. The bench keeps to both rules:
- it drives only one strobe or one tick per task step;
- after the last tick of each interval it waits several idle cycles before touching the register port again.

Under those rules, the flag register can change only through a control write or an expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Control byte fields
  localparam int RES_LSB   = 0;
  localparam int MULT_LSB  = 2;
  localparam int STEER_BIT = 7;
  // Flag register bit
  localparam int FLAG_BIT  = 7;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_IRQ   = 2'd1,
    ACT_RESET = 2'd2
  } wdt_act_e;
endpackage

// File: rtl/wdt_limit.sv
// Turns multiplier and resolution code into a tick count: mult << (2*res).
module wdt_limit #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
  input  logic [MULT_W-1:0] mult,
  input  logic [RES_W-1:0]  res,
  output logic [CNT_W-1:0]  limit
);
  localparam int NRES = 1 << RES_W;

  logic [CNT_W-1:0] scaled [NRES];

  for (genvar r = 0; r < NRES; r++) begin : g_scale
    assign scaled[r] = CNT_W'(mult) << (2 * r);
  end

  assign limit = scaled[res];
endmodule

// File: rtl/wdt_count.sv
// One-shot tick counter; latches its limit at restart.
module wdt_count #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit_in,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      lim_q   <= '0;
      armed_q <= 1'b0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (restart) begin
        cnt_q   <= '0;
        lim_q   <= limit_in;
        armed_q <= (limit_in != '0);
      end else if (armed_q && tick) begin
        if (cnt_nx == lim_q) begin
          cnt_q   <= '0;
          armed_q <= 1'b0;
          expire  <= 1'b1;
        end else begin
          cnt_q <= cnt_nx;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer #(
  parameter int          ADDR_W    = 13,
  parameter int          MULT_W    = 5,
  parameter int          RES_W     = 2,
  parameter logic [12:0] CTRL_ADDR = 13'h1FF7,
  parameter logic [12:0] FLAG_ADDR = 13'h1FF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              rst_req,
  output logic              irq,
  output logic              ext_clr
);
  import wdt_pkg::*;

  localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);

  logic [7:0]       ctrl_q;
  logic             flag_q;
  logic             wr_ctrl, rd_flag, restart;
  logic [7:0]       load_val;
  logic [CNT_W-1:0] limit;
  logic             wd_expire;
  wdt_act_e         act;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));
  assign rd_flag  = reg_rd && (reg_addr == ADDR_W'(FLAG_ADDR));
  assign restart  = wr_ctrl || rd_flag;
  assign load_val = wr_ctrl ? reg_wdata : ctrl_q;

  wdt_limit #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_limit (
    .mult  (load_val[MULT_LSB +: MULT_W]),
    .res   (load_val[RES_LSB +: RES_W]),
    .limit (limit)
  );

  wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .limit_in (limit),
    .tick     (tick),
    .expire   (wd_expire)
  );

  always_comb begin
    if (!wd_expire)            act = ACT_NONE;
    else if (ctrl_q[STEER_BIT]) act = ACT_RESET;
    else                        act = ACT_IRQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= 8'h00;
      flag_q    <= 1'b0;
      rst_req   <= 1'b0;
      irq       <= 1'b0;
      ext_clr   <= 1'b0;
      reg_rdata <= 8'h00;
    end else begin
      rst_req <= (act == ACT_RESET);
      ext_clr <= (act == ACT_RESET);
      irq     <= (act == ACT_IRQ);

      if (act == ACT_RESET) ctrl_q <= 8'h00;
      if (wr_ctrl)          ctrl_q <= reg_wdata;

      if (wd_expire)    flag_q <= 1'b1;
      else if (wr_ctrl) flag_q <= 1'b0;

      if (reg_rd) begin
        if (reg_addr == ADDR_W'(CTRL_ADDR))      reg_rdata <= ctrl_q;
        else if (reg_addr == ADDR_W'(FLAG_ADDR)) reg_rdata <= {flag_q, 7'b0};
        else                                     reg_rdata <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/wdt_steer_chk.sv
module wdt_steer_chk #(
  parameter int          ADDR_W    = 13,
  parameter logic [12:0] CTRL_ADDR = 13'h1FF7
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_rdata,
  input logic              rst_req,
  input logic              irq,
  input logic              ext_clr,
  input logic              expire,
  input logic              flag,
  input logic [7:0]        ctrl
);
  logic wr_c;
  assign wr_c = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (reg_rdata == 8'h00) && !irq && !rst_req && !ext_clr);

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R6
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R6
  rst_side_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> ext_clr && !irq && (ctrl == 8'h00));

  // R7
  wr_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_c && !expire) |=> !flag);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_c && !expire) |=> $stable(flag));

  // R4
  expire_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag);
endmodule

bind wdt_steer wdt_steer_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .rst_req   (rst_req),
  .irq       (irq),
  .ext_clr   (ext_clr),
  .expire    (wd_expire),
  .flag      (flag_q),
  .ctrl      (ctrl_q)
);

// File: tb/test_wdt_steer.sv
module test_wdt_steer;
  localparam logic [12:0] A_CTRL = 13'h1FF7;
  localparam logic [12:0] A_FLAG = 13'h1FF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [12:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        rst_req, irq, ext_clr;

  int n_chk  = 0;
  int n_fail = 0;
  int irq_cyc = 0, rst_cyc = 0, clr_cyc = 0;

  always #2 clk = ~clk;

  wdt_steer i_wdt_steer (
    .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rst_req(rst_req), .irq(irq), .ext_clr(ext_clr)
  );

  always @(negedge clk) begin
    if (irq)     irq_cyc++;
    if (rst_req) rst_cyc++;
    if (ext_clr) clr_cyc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    irq_cyc = 0; rst_cyc = 0; clr_cyc = 0;
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(!irq && !rst_req && !ext_clr, "R1 outputs", {irq, rst_req, ext_clr}, 0);
    rd(A_CTRL, d); chk(d == 8'h00, "R1 ctrl", d, 0);
    rd(A_FLAG, d); chk(d == 8'h00, "R1 flag", d, 0);
    clr_counts(); ticks(10);
    chk(irq_cyc == 0 && rst_cyc == 0, "R1 idle", irq_cyc + rst_cyc, 0);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    wr(A_CTRL, 8'h00); wr(A_CTRL, 8'h5A);
    rd(A_CTRL, d); chk(d == 8'h5A, "R2 readback", d, 8'h5A);
    wr(A_CTRL, 8'h00);
  endtask

  // mult, res, steer clear: irq on exact tick
  task automatic t_interval(input int mult, input int res);
    int n = mult << (2 * res);
    logic [7:0] d;
    clr_counts();
    wr(A_CTRL, 8'((mult << 2) | res));
    ticks(n - 1);
    chk(irq_cyc == 0, "R3 early", irq_cyc, 0);
    ticks(1);
    chk(irq_cyc == 1, "R3 on time / R5 one cycle", irq_cyc, 1);
    chk(rst_cyc == 0 && clr_cyc == 0, "R5 no reset", rst_cyc + clr_cyc, 0);
    ticks(n + 2);
    chk(irq_cyc == 1, "R11 one-shot", irq_cyc, 1);
    rd(A_FLAG, d); chk(d == 8'h80, "R4 flag", d, 8'h80);
  endtask

  task automatic t_steer_reset();
    logic [7:0] d;
    clr_counts();
    wr(A_CTRL, 8'h80 | (3 << 2) | 0);
    ticks(3);
    chk(rst_cyc == 1, "R6 rst_req", rst_cyc, 1);
    chk(clr_cyc == 1, "R6 ext_clr", clr_cyc, 1);
    chk(irq_cyc == 0, "R6 no irq", irq_cyc, 0);
    rd(A_CTRL, d); chk(d == 8'h00, "R6 ctrl cleared", d, 0);
    rd(A_FLAG, d); chk(d == 8'h80, "R4 flag after reset path", d, 8'h80);
  endtask

  task automatic t_write_clears();
    logic [7:0] d;
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, d); chk(d == 8'h80, "R9 write ignored (set)", d, 8'h80);
    wr(A_CTRL, 8'h00);
    rd(A_FLAG, d); chk(d == 8'h00, "R7 flag cleared", d, 0);
    wr(A_FLAG, 8'hFF);
    rd(A_FLAG, d); chk(d == 8'h00, "R9 write ignored (clear)", d, 0);
  endtask

  task automatic t_disabled();
    clr_counts();
    wr(A_CTRL, 8'h03);
    ticks(80);
    chk(irq_cyc == 0 && rst_cyc == 0, "R10 disabled", irq_cyc + rst_cyc, 0);
  endtask

  task automatic t_read_kick();
    logic [7:0] d;
    clr_counts();
    wr(A_CTRL, 8'(2 << 2));
    ticks(1); rd(A_FLAG, d);
    ticks(1);
    chk(irq_cyc == 0, "R8 read restarts", irq_cyc, 0);
    ticks(1);
    chk(irq_cyc == 1, "R8 expiry after restart", irq_cyc, 1);
  endtask

  task automatic t_rewrite_restart();
    clr_counts();
    wr(A_CTRL, 8'(4 << 2));
    ticks(3);
    wr(A_CTRL, 8'(2 << 2));
    ticks(1);
    chk(irq_cyc == 0, "R7 rewrite restarts", irq_cyc, 0);
    ticks(1);
    chk(irq_cyc == 1, "R7 new interval", irq_cyc, 1);
  endtask

  task automatic t_sys_reset();
    logic [7:0] d;
    clr_counts();
    wr(A_CTRL, 8'(2 << 2));
    ticks(1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    ticks(4);
    chk(irq_cyc == 0, "R1 counter cleared", irq_cyc, 0);
    rd(A_CTRL, d); chk(d == 8'h00, "R1 ctrl after reset", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readback();
    t_interval(3, 0);
    t_interval(1, 1);
    t_interval(5, 2);
    t_interval(31, 3);
    t_steer_reset();
    t_write_clears();
    t_disabled();
    t_read_kick();
    t_rewrite_restart();
    t_sys_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #700000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule